// File: doc/BRIEF.md
# Shared-Buffer Data-Link Scheduler

This block sits between the output-channel arbiters of a router and the per-output shallow buffers. Each output channel presents at most one granted flit per cycle. The scheduler sends that flit in one of two directions. It can write the flit straight into that output's shallow buffer. It can also park the flit in a central store of words that every output channel shares. Words in the shared store are not split among the outputs in advance. An output takes words as it needs them, so one congested output may hold all of them.

The shared store has a single port, so each cycle it performs one read, one write, or nothing. For every output the block keeps a linked list of its parked words, and it keeps a list of free words. The next write address is the head of the free list. When an output's shallow buffer shows space and that output has parked words, the oldest word is read and forwarded to the output. A flit bound for the shared store is only accepted when a free word exists and no read is using the port. Otherwise the sender keeps its request raised until it is accepted.

Top module: `dls_shared_buf`

## Requirements
- R1: A flit on channel k is accepted in the same cycle (`in_ack[k]`=1) and appears on `out_wr[k]`/`out_data` one cycle later, when the shared store holds no words for k and `out_full[k]`=0 in the cycle of acceptance. Several channels may take this direct path in the same cycle.
- R2: If `out_full[k]`=1, or the shared store holds any word for k, the flit is not passed straight to the output. It is written to the shared store, or left waiting if it cannot be written.
- R3: Flits for each output leave on `out_wr`/`out_data` in the order in which they were accepted, whichever path each one took.
- R4: `out_wr[k]` is never 1 in the cycle after a cycle in which `out_full[k]` was 1. When `out_full[k]`=0 and k has parked words, the oldest one is read and delivered in the next cycle.
- R5: The shared store performs at most one access per cycle. A drain read has priority over writes, and at most one flit per cycle is accepted into the shared store.
- R6: While all DEPTH words are in use, no flit bound for the shared store is accepted until a read frees a word.
- R7: When several channels compete to write into the shared store, they are served in round-robin order. Within any run of consecutive writes with all four channels requesting, no channel is served twice before the others.
- R8: While `rst`=1, `in_ack` and `out_wr` are 0. After reset the shared store is empty, so the first flit takes the direct path.
- R9: A single output can hold all DEPTH shared words, and every parked word is delivered once that output's buffer has space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | NCH | Per-channel flit request, held until acknowledged |
| in_data | input | NCH*DW | Channel k flit at bits [k*DW +: DW] |
| in_ack | output | NCH | Per-channel accept, same cycle as the request |
| out_full | input | NCH | Per-output shallow buffer cannot take a word next cycle |
| out_wr | output | NCH | Per-output write strobe into the shallow buffer |
| out_data | output | NCH*DW | Output k word at bits [k*DW +: DW] |

## Verification
Two events can fall in the same cycle and compete for the one port of the shared store: a drain read for an output whose buffer has just freed up, and a new flit that needs to be parked for another output. The bench triggers this directly. It parks three words on one output, then clears that output's full flag in the same cycle that a flit arrives for a second output whose buffer is full. It then checks that the flit is accepted in exactly the third cycle after the release, once the three reads are done. A second case clears a full flag in the same cycle that a new flit arrives for that same output. The bench checks that the parked word is delivered first and that the new flit goes through only one cycle later.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;

endpackage

// File: rtl/dls_rr_arb.sv
module dls_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] gidx;
  logic          hit;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    hit  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!hit && req[(int'(ptr) + i) % N]) begin
        gnt[(int'(ptr) + i) % N] = 1'b1;
        gidx = PW'((int'(ptr) + i) % N);
        hit  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv && hit) begin
      ptr <= (int'(gidx) == N - 1) ? '0 : gidx + 1'b1;
    end
  end

  // R7: a grant goes to one requester at most, and only to one that asks
  assert_grant_valid_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));

endmodule

// File: rtl/dls_store.sv
module dls_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    if (re) begin
      rdata <= mem[addr];
    end
  end

  // R5: the single port never carries a read and a write together
  assert_single_port_R5: assert property (@(posedge clk) disable iff (rst)
    !(we && re));

endmodule

// File: rtl/dls_link_mgr.sv
module dls_link_mgr #(
  parameter int NCH   = 4,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic           rd_en,
  input  logic [CHW-1:0] rd_ch,
  output logic [AW-1:0]  wr_addr,
  output logic [AW-1:0]  rd_addr,
  output logic [NCH-1:0] occ_nz,
  output logic           full
);
  logic [AW-1:0] nxt  [DEPTH];
  logic [AW-1:0] head [NCH];
  logic [AW-1:0] tail [NCH];
  logic [CW-1:0] cnt  [NCH];
  logic [AW-1:0] free_head;
  logic [AW-1:0] free_tail;
  logic [CW-1:0] free_cnt;
  int            occ_total;

  assign wr_addr = free_head;
  assign rd_addr = head[rd_ch];
  assign full    = (free_cnt == '0);

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_nz
      assign occ_nz[g] = (cnt[g] != '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        nxt[i] <= AW'((i + 1) % DEPTH);
      end
      for (int c = 0; c < NCH; c++) begin
        head[c] <= '0;
        tail[c] <= '0;
        cnt[c]  <= '0;
      end
      free_head <= '0;
      free_tail <= AW'(DEPTH - 1);
      free_cnt  <= CW'(DEPTH);
    end else if (wr_en) begin
      free_head <= nxt[free_head];
      free_cnt  <= free_cnt - 1'b1;
      if (cnt[wr_ch] == '0) begin
        head[wr_ch] <= free_head;
      end else begin
        nxt[tail[wr_ch]] <= free_head;
      end
      tail[wr_ch] <= free_head;
      cnt[wr_ch]  <= cnt[wr_ch] + 1'b1;
    end else if (rd_en) begin
      head[rd_ch] <= nxt[head[rd_ch]];
      cnt[rd_ch]  <= cnt[rd_ch] - 1'b1;
      if (free_cnt == '0) begin
        free_head <= head[rd_ch];
      end else begin
        nxt[free_tail] <= head[rd_ch];
      end
      free_tail <= head[rd_ch];
      free_cnt  <= free_cnt + 1'b1;
    end
  end

  always_comb begin
    occ_total = int'(free_cnt);
    for (int c = 0; c < NCH; c++) begin
      occ_total = occ_total + int'(cnt[c]);
    end
  end

  // R6: no word is taken from an empty free list
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (free_cnt != '0));

  // R4: a drain read only targets an output that has parked words
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (cnt[rd_ch] != '0));

  // R9: the per-output counts and the free count always cover the whole store
  assert_words_conserved_R9: assert property (@(posedge clk) disable iff (rst)
    occ_total == DEPTH);

endmodule

// File: rtl/dls_shared_buf.sv
module dls_shared_buf
  import dls_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    in_req,
  input  logic [NCH*DW-1:0] in_data,
  output logic [NCH-1:0]    in_ack,
  input  logic [NCH-1:0]    out_full,
  output logic [NCH-1:0]    out_wr,
  output logic [NCH*DW-1:0] out_data
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] occ_nz;
  logic           sh_full;
  logic [NCH-1:0] byp;
  logic [NCH-1:0] rd_req;
  logic [NCH-1:0] wr_req;
  logic [NCH-1:0] rd_gnt;
  logic [NCH-1:0] wr_gnt;
  logic           do_rd;
  logic           do_wr;
  logic [CHW-1:0] rd_ch;
  logic [CHW-1:0] wr_ch;
  logic [AW-1:0]  wr_addr;
  logic [AW-1:0]  rd_addr;
  logic [DW-1:0]  wr_word;
  logic [DW-1:0]  st_q;
  acc_e           acc;

  logic [NCH-1:0] byp_q;
  logic [DW-1:0]  byp_data_q [NCH];
  logic           rd_v_q;
  logic [CHW-1:0] rd_ch_q;

  // Path choice per output channel
  assign byp    = in_req & ~occ_nz & ~out_full & {NCH{~rst}};
  assign rd_req = occ_nz & ~out_full & {NCH{~rst}};
  assign wr_req = in_req & ~byp & {NCH{~rst}};

  dls_rr_arb #(.N(NCH)) u_rd_arb (
    .clk (clk),
    .rst (rst),
    .req (rd_req),
    .adv (do_rd),
    .gnt (rd_gnt)
  );

  dls_rr_arb #(.N(NCH)) u_wr_arb (
    .clk (clk),
    .rst (rst),
    .req (wr_req),
    .adv (do_wr),
    .gnt (wr_gnt)
  );

  // Read wins the single port; a write also needs a free word
  assign do_rd = (|rd_gnt);
  assign do_wr = (|wr_gnt) && !do_rd && !sh_full;

  always_comb begin
    if (do_rd) begin
      acc = ACC_READ;
    end else if (do_wr) begin
      acc = ACC_WRITE;
    end else begin
      acc = ACC_IDLE;
    end
  end

  always_comb begin
    rd_ch = '0;
    wr_ch = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_gnt[i]) rd_ch = CHW'(i);
      if (wr_gnt[i]) wr_ch = CHW'(i);
    end
  end

  assign wr_word = in_data[int'(wr_ch)*DW +: DW];
  assign in_ack  = byp | (wr_gnt & {NCH{do_wr}});

  dls_link_mgr #(.NCH(NCH), .DEPTH(DEPTH)) u_links (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (acc == ACC_WRITE),
    .wr_ch   (wr_ch),
    .rd_en   (acc == ACC_READ),
    .rd_ch   (rd_ch),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .occ_nz  (occ_nz),
    .full    (sh_full)
  );

  dls_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (acc == ACC_WRITE),
    .re    (acc == ACC_READ),
    .addr  ((acc == ACC_READ) ? rd_addr : wr_addr),
    .wdata (wr_word),
    .rdata (st_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q   <= '0;
      rd_v_q  <= 1'b0;
      rd_ch_q <= '0;
    end else begin
      byp_q   <= byp;
      rd_v_q  <= do_rd;
      rd_ch_q <= rd_ch;
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_out
      logic drain_hit;

      always_ff @(posedge clk) begin
        if (byp[g]) begin
          byp_data_q[g] <= in_data[g*DW +: DW];
        end
      end

      assign drain_hit         = rd_v_q && (int'(rd_ch_q) == g);
      assign out_wr[g]         = byp_q[g] | drain_hit;
      assign out_data[g*DW +: DW] = drain_hit ? st_q : byp_data_q[g];

      // R4: nothing is written into a shallow buffer that flagged full
      assert_no_wr_on_full_R4: assert property (@(posedge clk) disable iff (rst)
        out_wr[g] |-> !$past(out_full[g]));

      // R1: direct path and drain never target one output in the same cycle
      assert_one_source_R1: assert property (@(posedge clk) disable iff (rst)
        !(byp_q[g] && drain_hit));
    end
  endgenerate

  // R5: at most one flit per cycle enters the shared store
  assert_one_shared_write_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(in_ack & ~byp) <= 1);

  // R8: nothing accepted while reset is held
  assert_quiet_in_reset_R8: assert property (@(posedge clk)
    rst |-> (in_ack == '0));

endmodule

// File: tb/dls_shared_buf_bench.sv
`timescale 1ns/1ps
module dls_shared_buf_bench;
  localparam int NCH   = 4;
  localparam int DEPTH = 16;
  localparam int DW    = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    in_req = '0;
  logic [NCH*DW-1:0] in_data = '0;
  logic [NCH-1:0]    in_ack;
  logic [NCH-1:0]    out_full = '0;
  logic [NCH-1:0]    out_wr;
  logic [NCH*DW-1:0] out_data;

  always #10 clk = ~clk;

  dls_shared_buf #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW)) u_dls_shared_buf (
    .clk      (clk),
    .rst      (rst),
    .in_req   (in_req),
    .in_data  (in_data),
    .in_ack   (in_ack),
    .out_full (out_full),
    .out_wr   (out_wr),
    .out_data (out_data)
  );

  logic [DW-1:0]  src_q [NCH][$];
  logic [DW-1:0]  exp_q [NCH][$];
  logic [NCH-1:0] full_ctl = '0;
  logic [NCH-1:0] prev_full = '0;
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int ack_cyc [NCH];
  int wr_cyc  [NCH];
  int ack_cnt [NCH];
  int wr_cnt  [NCH];
  logic [DW-1:0] last_wr [NCH];
  int ack_ch_log [$];
  int ack_cy_log [$];
  int seq = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [DW-1:0] mkflit(input int ch);
    seq++;
    return {8'(ch + 8'hA0), 24'(seq)};
  endfunction

  // Driver and monitor: drive just after the falling edge, sample just before the rising edge
  initial begin
    for (int o = 0; o < NCH; o++) begin
      ack_cyc[o] = -1; wr_cyc[o] = -1; ack_cnt[o] = 0; wr_cnt[o] = 0; last_wr[o] = '0;
    end
    forever begin
      @(negedge clk);
      #1;
      for (int o = 0; o < NCH; o++) begin
        in_req[o] = (src_q[o].size() != 0);
        in_data[o*DW +: DW] = (src_q[o].size() != 0) ? src_q[o][0] : '0;
      end
      out_full = full_ctl;
      #8;
      cyc++;
      for (int o = 0; o < NCH; o++) begin
        if (in_ack[o]) begin
          ack_cyc[o] = cyc;
          ack_cnt[o]++;
          ack_ch_log.push_back(o);
          ack_cy_log.push_back(cyc);
          if (src_q[o].size() != 0) begin
            exp_q[o].push_back(src_q[o].pop_front());
          end else begin
            chk(1'b0, "R1 ack without request", 1, 0);
          end
        end
        if (out_wr[o]) begin
          wr_cyc[o] = cyc;
          wr_cnt[o]++;
          last_wr[o] = out_data[o*DW +: DW];
          chk(!prev_full[o], "R4 write after full", 1, 0);
          if (exp_q[o].size() == 0) begin
            chk(1'b0, "R3 unexpected delivery", out_data[o*DW +: DW], 0);
          end else begin
            logic [DW-1:0] e;
            e = exp_q[o].pop_front();
            chk(out_data[o*DW +: DW] == e, "R3 order", out_data[o*DW +: DW], e);
          end
        end
      end
      prev_full = out_full;
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", cyc, 150000);
        finish_run();
      end
    end
  end

  function automatic bit busy();
    for (int o = 0; o < NCH; o++) begin
      if (src_q[o].size() != 0 || exp_q[o].size() != 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic wait_drain(input string req);
    int n;
    n = 0;
    while (busy() && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
    chk(n < 3000, req, n, 3000);
  endtask

  task automatic t_reset();
    int tot;
    rst = 1'b1;
    full_ctl = '0;
    src_q[0].push_back(mkflit(0));
    repeat (5) @(negedge clk);
    tot = 0;
    for (int o = 0; o < NCH; o++) tot += wr_cnt[o];
    chk(ack_cnt[0] == 0, "R8 no ack in reset", ack_cnt[0], 0);
    chk(tot == 0, "R8 no write in reset", tot, 0);
    rst = 1'b0;
    wait_drain("R8 first flit delivered");
    chk(wr_cnt[0] == 1, "R8 delivery after reset", wr_cnt[0], 1);
  endtask

  task automatic t_bypass();
    int c;
    logic [DW-1:0] d0, d1;
    @(negedge clk);
    d0 = mkflit(0);
    d1 = mkflit(1);
    src_q[0].push_back(d0);
    src_q[1].push_back(d1);
    c = cyc + 1;
    repeat (3) @(negedge clk);
    chk(ack_cyc[0] == c, "R1 ack cycle ch0", ack_cyc[0], c);
    chk(ack_cyc[1] == c, "R1 ack cycle ch1", ack_cyc[1], c);
    chk(wr_cyc[0] == c + 1, "R1 write cycle ch0", wr_cyc[0], c + 1);
    chk(wr_cyc[1] == c + 1, "R1 write cycle ch1", wr_cyc[1], c + 1);
    chk(last_wr[1] == d1, "R1 data ch1", last_wr[1], d1);
    wait_drain("R1 drain");
  endtask

  task automatic t_shared_path();
    int c, a0, w0;
    logic [DW-1:0] da, db;
    a0 = ack_cnt[1];
    w0 = wr_cnt[1];
    @(negedge clk);
    full_ctl[1] = 1'b1;
    da = mkflit(1);
    src_q[1].push_back(da);
    repeat (4) @(negedge clk);
    chk(ack_cnt[1] - a0 == 1, "R2 parked while full", ack_cnt[1] - a0, 1);
    chk(wr_cnt[1] - w0 == 0, "R2 no delivery while full", wr_cnt[1] - w0, 0);
    full_ctl[1] = 1'b0;
    db = mkflit(1);
    src_q[1].push_back(db);
    c = cyc + 1;
    repeat (4) @(negedge clk);
    chk(ack_cyc[1] == c + 1, "R2 new flit held behind parked word", ack_cyc[1], c + 1);
    chk(wr_cyc[1] == c + 2, "R2 new flit delivered second", wr_cyc[1], c + 2);
    chk(last_wr[1] == db, "R2 last data", last_wr[1], db);
    wait_drain("R2 drain");
  endtask

  task automatic t_capacity();
    int a0, w0;
    a0 = ack_cnt[2];
    w0 = wr_cnt[2];
    @(negedge clk);
    full_ctl[2] = 1'b1;
    for (int i = 0; i < DEPTH + 2; i++) src_q[2].push_back(mkflit(2));
    repeat (DEPTH + 10) @(negedge clk);
    chk(ack_cnt[2] - a0 == DEPTH, "R6 accepts stop at capacity", ack_cnt[2] - a0, DEPTH);
    chk(wr_cnt[2] - w0 == 0, "R9 one output holds every word", wr_cnt[2] - w0, 0);
    full_ctl[2] = 1'b0;
    wait_drain("R6 drain");
    chk(wr_cnt[2] - w0 == DEPTH + 2, "R9 all delivered", wr_cnt[2] - w0, DEPTH + 2);
  endtask

  task automatic t_round_robin();
    int base;
    bit distinct;
    bit rotates;
    bit one_per_cycle;
    @(negedge clk);
    base = ack_ch_log.size();
    full_ctl = '1;
    for (int o = 0; o < NCH; o++) begin
      src_q[o].push_back(mkflit(o));
      src_q[o].push_back(mkflit(o));
    end
    repeat (14) @(negedge clk);
    chk(ack_ch_log.size() - base == 2 * NCH, "R7 all parked", ack_ch_log.size() - base, 2 * NCH);
    distinct = 1'b1;
    rotates = 1'b1;
    one_per_cycle = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      for (int j = i + 1; j < NCH; j++) begin
        if (ack_ch_log[base + i] == ack_ch_log[base + j]) distinct = 1'b0;
      end
      if (ack_ch_log[base + i] != ack_ch_log[base + i + NCH]) rotates = 1'b0;
    end
    for (int i = 1; i < 2 * NCH; i++) begin
      if (ack_cy_log[base + i] == ack_cy_log[base + i - 1]) one_per_cycle = 1'b0;
    end
    chk(distinct, "R7 no channel served twice first", distinct, 1);
    chk(rotates, "R7 rotation repeats", rotates, 1);
    chk(one_per_cycle, "R5 one shared write per cycle", one_per_cycle, 1);
    full_ctl = '0;
    wait_drain("R7 drain");
  endtask

  task automatic t_read_priority();
    int c, w0;
    w0 = wr_cnt[3];
    @(negedge clk);
    full_ctl[3] = 1'b1;
    full_ctl[0] = 1'b1;
    for (int i = 0; i < 3; i++) src_q[3].push_back(mkflit(3));
    repeat (6) @(negedge clk);
    full_ctl[3] = 1'b0;
    src_q[0].push_back(mkflit(0));
    c = cyc + 1;
    repeat (8) @(negedge clk);
    chk(ack_cyc[0] == c + 3, "R5 write waits for drain reads", ack_cyc[0], c + 3);
    chk(wr_cyc[3] == c + 3, "R4 drain ends after three reads", wr_cyc[3], c + 3);
    chk(wr_cnt[3] - w0 == 3, "R4 drain count", wr_cnt[3] - w0, 3);
    full_ctl[0] = 1'b0;
    wait_drain("R5 drain");
  endtask

  task automatic t_mixed();
    logic [15:0] lfsr;
    int ta, tw;
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      full_ctl = lfsr[3:0] & lfsr[7:4];
      for (int o = 0; o < NCH; o++) begin
        if (lfsr[8 + o] && src_q[o].size() < 4) src_q[o].push_back(mkflit(o));
      end
    end
    full_ctl = '0;
    wait_drain("R3 mixed drain");
    ta = 0;
    tw = 0;
    for (int o = 0; o < NCH; o++) begin
      ta += ack_cnt[o];
      tw += wr_cnt[o];
    end
    chk(ta == tw, "R3 every accepted flit delivered", tw, ta);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_shared_path();
    t_capacity();
    t_round_robin();
    t_read_priority();
    t_mixed();
    finish_run();
  end

endmodule